// File: doc/BRIEF.md
# Burst-of-Two Separate-Port DDR SRAM Model

This block is a synthesizable behavioural model of a synchronous static RAM with one data bus going in and another coming out. Both buses move data on both clock edges in bursts of two beats, and a single address bus serves both sides. A read is issued on the rising edge of `k`. A write is issued on the same edge but takes its address half a cycle later, on the rising edge of `k_n`. One read and one write can therefore start in every cycle.

Each array word is two beats wide. Write beats are gathered and stored in one step, with a separate byte mask for each beat. A read fetches a whole word and sends the lower half first and the upper half second. Output timing follows the optional output clocks `c`/`c_n`. When both of those are held high, the outputs fall back to `k`/`k_n`. Instead of a tri-state bus, the model drives the output bus together with an enable flag.

Top module: `sio_ddr_burst2_ram`

## Requirements
- R1: On a rising edge of `k` with `rd_n` low, the model starts a read of the word at `addr` sampled on that same edge.
- R2: The lower half of a word read at edge n appears on `q` at rising edge n+1 of the output clock, and the upper half appears at the following rising edge of the inverted output clock. Reads may be issued in consecutive cycles with no gap.
- R3: `q_oe` is high through both beat slots of a read and low through both slots of a cycle in which `rd_n` was high.
- R4: `wr_n`, the first beat `d` and its mask are sampled on a rising edge of `k`. The write address and the second beat with its mask are sampled on the next rising edge of `k_n`. The first beat fills the lower half of the word and the second beat fills the upper half.
- R5: Byte lane j of a beat covers bits 9j to 9j+8. When `bw_n[j]` is high while a beat is sampled, that lane of that half of the word keeps its previous contents, and the other lanes are written.
- R6: A write with every mask bit high on both beats leaves the addressed word unchanged.
- R7: A read and a write may be issued in the same cycle. A read returns the data of every write issued in the same cycle or earlier, including a write to the same address issued in the same cycle.
- R8: When `c` and `c_n` are both held high, `k` and `k_n` launch the output beats. Otherwise a rising edge of `c` launches the first beat and a rising edge of `c_n` launches the second.
- R9: While `rst_n` is low, `q_oe` is low and any read or write in flight is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k | input | 1 | Primary clock; commands and first write beat |
| k_n | input | 1 | Inverted primary clock; write address and second beat |
| c | input | 1 | Output clock for first read beat (hold high with `c_n` to use `k`) |
| c_n | input | 1 | Output clock for second read beat |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline state |
| addr | input | AW | Word address, read on `k`, write on `k_n` |
| rd_n | input | 1 | Active-low read request |
| wr_n | input | 1 | Active-low write request |
| bw_n | input | BYTES | Active-low per-lane write mask, one set per beat |
| d | input | 9*BYTES | Write data beat |
| q | output | 9*BYTES | Read data beat |
| q_oe | output | 1 | High while `q` carries read data |

## Verification
A read issued on `k` edge n is due on `q` three time units after edge n+1 (first beat) and three time units after the `k_n` edge that follows (second beat). Each sample sits well away from both output clock edges, so the bench also works with the output clocks delayed by one unit. Whenever the bench issues a command, it records the expected word and enable for the slot two counted edges ahead, and a monitor compares only in that slot. The expected word comes from a bench-side array that applies each write, with its lane masks, before the read of the same cycle is evaluated.

// File: rtl/sio_ddr_burst2_ram.sv
module sio_ddr_burst2_ram #(
  parameter int AW    = 4,
  parameter int BYTES = 2
) (
  input  logic                 k,
  input  logic                 k_n,
  input  logic                 c,
  input  logic                 c_n,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic [BYTES-1:0]     bw_n,
  input  logic [9*BYTES-1:0]   d,
  output logic [9*BYTES-1:0]   q,
  output logic                 q_oe
);
  localparam int LW    = 9;
  localparam int DW    = LW * BYTES;
  localparam int WW    = 2 * DW;
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0]    mem [DEPTH];
  logic             rd_go, rd_go2, wr_go, oe_r, ph_a, ph_b;
  logic [AW-1:0]    rd_a, rd_a2;
  logic [DW-1:0]    d0, lo_r, hi_r;
  logic [BYTES-1:0] m0;
  logic [1:0]       warm;

  wire c_tied = c & c_n;
  wire oclk   = c_tied ? k   : c;
  wire oclk_n = c_tied ? k_n : c_n;

  always_ff @(posedge k or negedge rst_n)
    if (!rst_n) begin
      rd_go <= 1'b0; wr_go <= 1'b0; rd_a <= '0; d0 <= '0; m0 <= '1;
    end else begin
      rd_go <= ~rd_n; wr_go <= ~wr_n; rd_a <= addr; d0 <= d; m0 <= bw_n;
    end

  always_ff @(posedge k_n or negedge rst_n)
    if (!rst_n) begin
      rd_go2 <= 1'b0; rd_a2 <= '0;
    end else begin
      rd_go2 <= rd_go; rd_a2 <= rd_a;
    end

  always_ff @(posedge k_n)
    if (wr_go && rst_n)
      for (int j = 0; j < BYTES; j++) begin
        if (!m0[j])   mem[addr][j*LW +: LW]      <= d0[j*LW +: LW];
        if (!bw_n[j]) mem[addr][DW + j*LW +: LW] <= d[j*LW +: LW];
      end

  always_ff @(posedge oclk or negedge rst_n)
    if (!rst_n) begin
      oe_r <= 1'b0; ph_a <= 1'b0; lo_r <= '0; hi_r <= '0;
    end else begin
      oe_r <= rd_go2;
      ph_a <= ~ph_a;
      if (rd_go2) {hi_r, lo_r} <= mem[rd_a2];
    end

  always_ff @(posedge oclk_n or negedge rst_n)
    if (!rst_n) ph_b <= 1'b0;
    else        ph_b <= ph_a;

  assign q    = (ph_a == ph_b) ? hi_r : lo_r;
  assign q_oe = oe_r;

  always_ff @(posedge k or negedge rst_n)
    if (!rst_n)            warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;

  p_rd_stage_r1: assert property (@(posedge k) disable iff (!rst_n)
    (warm != 2'd0) |-> (rd_go == !$past(rd_n)));

  p_rd_addr_r1: assert property (@(posedge k) disable iff (!rst_n)
    (warm != 2'd0 && !$past(rd_n)) |-> (rd_a == $past(addr)));

  p_rd_pipe_r2: assert property (@(posedge k_n) disable iff (!rst_n)
    (warm == 2'd3) |-> (rd_go2 == $past(rd_go) && rd_a2 == $past(rd_a)));

  p_oe_slot_r3: assert property (@(posedge k) disable iff (!rst_n)
    (warm == 2'd3 && c_tied && $past(c_tied)) |-> (q_oe == !$past(rd_n, 2)));
endmodule

// File: tb/sim_sio_ddr_burst2_ram.sv
module sim_sio_ddr_burst2_ram;
  localparam int PERIOD = 10;
  localparam int AW = 4, BY = 2, DW = 9 * BY, DEPTH = 1 << AW;

  logic k = 1'b0, kd, cmode = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic rd_n = 1'b1, wr_n = 1'b1;
  logic [BY-1:0] bw_n = '1;
  logic [DW-1:0] d = '0, q;
  logic q_oe;
  wire k_n = ~k;
  wire c   = cmode ? kd  : 1'b1;
  wire c_n = cmode ? ~kd : 1'b1;

  always #(PERIOD/2) k = ~k;
  always @(k) kd <= #1 k;

  sio_ddr_burst2_ram #(.AW(AW), .BYTES(BY)) u0 (
    .k(k), .k_n(k_n), .c(c), .c_n(c_n), .rst_n(rst_n), .addr(addr),
    .rd_n(rd_n), .wr_n(wr_n), .bw_n(bw_n), .d(d), .q(q), .q_oe(q_oe));

  int checks = 0, errs = 0, cyc = 0;
  logic [2*DW-1:0] rm [DEPTH];
  bit               pend  [64];
  bit               e_oe  [64];
  logic [2*DW-1:0]  e_w   [64];
  string            e_tag [64];

  task automatic chk(string tg, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tg, got, exp);
    end
  endtask

  always @(posedge k) begin
    int s;
    cyc = cyc + 1;
    s = cyc % 64;
    #3;
    if (pend[s]) begin
      chk({e_tag[s], " enable beat0"}, 64'(q_oe), 64'(e_oe[s]));
      if (e_oe[s]) chk({e_tag[s], " beat0"}, 64'(q), 64'(e_w[s][DW-1:0]));
    end
    #(PERIOD/2);
    if (pend[s]) begin
      chk({e_tag[s], " enable beat1"}, 64'(q_oe), 64'(e_oe[s]));
      if (e_oe[s]) chk({e_tag[s], " beat1"}, 64'(q), 64'(e_w[s][2*DW-1:DW]));
      pend[s] = 1'b0;
    end
  end

  task automatic issue(string tg, bit rd, int ra, bit wr, int wa,
                       logic [DW-1:0] a0, logic [BY-1:0] b0,
                       logic [DW-1:0] a1, logic [BY-1:0] b1);
    int s;
    @(negedge k); #3;
    rd_n = !rd; wr_n = !wr; addr = AW'(ra); d = a0; bw_n = b0;
    if (wr)
      for (int j = 0; j < BY; j++) begin
        if (!b0[j]) rm[wa][j*9 +: 9]      = a0[j*9 +: 9];
        if (!b1[j]) rm[wa][DW + j*9 +: 9] = a1[j*9 +: 9];
      end
    s = (cyc + 2) % 64;
    pend[s] = 1'b1; e_oe[s] = rd; e_tag[s] = tg;
    if (rd) e_w[s] = rm[ra];
    @(posedge k); #3;
    addr = AW'(wa); d = a1; bw_n = b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic idle(string tg, int n);
    for (int i = 0; i < n; i++) issue(tg, 0, 0, 0, 0, '0, '1, '0, '1);
  endtask

  task automatic t_fill;
    for (int a = 0; a < DEPTH; a++)
      issue("R4 fill", 0, 0, 1, a, DW'(a * 37 + 5), '0, DW'(a * 91 + 3), '0);
    idle("R3 fill idle", 2);
  endtask

  task automatic t_reset;
    chk("R9 enable after reset", 64'(q_oe), 64'(0));
    @(negedge k); #3; rd_n = 1'b0; addr = 2;
    @(posedge k); #1; rst_n = 1'b0; #2; rd_n = 1'b1;
    @(posedge k); #3;
    chk("R9 read dropped beat0", 64'(q_oe), 64'(0));
    #(PERIOD/2);
    chk("R9 read dropped beat1", 64'(q_oe), 64'(0));
    @(negedge k); rst_n = 1'b1;
    idle("R9 idle after reset", 4);
  endtask

  task automatic t_write_read;
    issue("R4 write", 0, 0, 1, 6, 18'h2abcd, '0, 18'h1f00f, '0);
    issue("R1 R2 read", 1, 6, 0, 0, '0, '1, '0, '1);
    idle("R3 idle", 2);
  endtask

  task automatic t_back_to_back;
    for (int a = 0; a < 6; a++) issue("R2 consecutive reads", 1, a, 0, 0, '0, '1, '0, '1);
    issue("R3 deselect between", 0, 0, 0, 0, '0, '1, '0, '1);
    issue("R3 read after gap", 1, 9, 0, 0, '0, '1, '0, '1);
    idle("R3 idle", 2);
  endtask

  task automatic t_masks;
    issue("R5 lane masks", 0, 0, 1, 7, 18'h3ffff, 2'b10, 18'h15555, 2'b01);
    issue("R5 read masked", 1, 7, 1, 8, 18'h00001, 2'b01, 18'h3fe00, 2'b10);
    issue("R5 read second", 1, 8, 0, 0, '0, '1, '0, '1);
    idle("R3 idle", 2);
  endtask

  task automatic t_full_mask;
    issue("R6 masked write", 0, 0, 1, 10, 18'h12345, 2'b11, 18'h2eeee, 2'b11);
    issue("R6 word unchanged", 1, 10, 0, 0, '0, '1, '0, '1);
    idle("R3 idle", 2);
  endtask

  task automatic t_same_cycle;
    issue("R7 read other while write", 1, 11, 1, 12, 18'h0aaaa, '0, 18'h05555, '0);
    issue("R7 read same addr same cycle", 1, 13, 1, 13, 18'h31111, '0, 18'h02222, 2'b10);
    issue("R7 read after write", 1, 12, 1, 12, 18'h00777, 2'b01, 18'h3c3c3, '0);
    issue("R7 read latest", 1, 12, 0, 0, '0, '1, '0, '1);
    idle("R3 idle", 2);
  endtask

  task automatic t_cclock;
    @(negedge k); cmode = 1'b1;
    idle("R8 settle", 2);
    issue("R8 read with output clocks", 1, 13, 0, 0, '0, '1, '0, '1);
    issue("R8 back to back", 1, 6, 1, 3, 18'h0c0c0, '0, 18'h30303, '0);
    issue("R8 read written", 1, 3, 0, 0, '0, '1, '0, '1);
    idle("R8 idle", 2);
    @(negedge k); cmode = 1'b0;
    idle("R8 back to tied", 2);
    issue("R8 tied again", 1, 3, 0, 0, '0, '1, '0, '1);
    idle("R3 idle", 2);
  endtask

  initial begin
    #(PERIOD * 20000);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge k);
    @(negedge k); rst_n = 1'b1;
    repeat (4) @(posedge k);
    t_reset;
    t_fill;
    t_write_read;
    t_back_to_back;
    t_masks;
    t_full_mask;
    t_same_cycle;
    t_cclock;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule